// File: doc/BRIEF.md
# Four-Direction Round-Robin Traffic Sequencer

This block drives the signal heads of a four-approach junction. One approach holds the right of way at a time. That approach shows green, then yellow, and then the next approach in a fixed rotation gets green. The rotation is north, south, east, west, and after west it starts again at north. It never stops while reset is low.

Each approach has a 2-bit lamp code. A dwell timer holds every phase for the same number of clock cycles. The default is 8 cycles, so one full lap of eight phases takes 64 cycles. The lamp codes are decoded from the registered phase, so all four outputs change on the same clock edge that moves the phase.

Top module: `tl_junction_rotator`

## Requirements
- R1: The lit approach and its colour follow the order north green, north yellow, south green, south yellow, east green, east yellow, west green, west yellow. Each change of the outputs moves exactly one step along that order.
- R3: Each lamp output uses the code 2'b10 for green, 2'b01 for yellow and 2'b00 for off. The code 2'b11 never appears.
- R4: In every cycle outside reset, exactly one of the four lamp outputs is non-zero.
- R5: While reset is high at a clock edge, the outputs become north green with the others off. After reset is released, north green lasts a full DWELL_CYCLES cycles, counted from the first non-reset edge. This holds whether reset comes at start-up or in the middle of a later phase.
- R6: Every green phase and every yellow phase lasts exactly DWELL_CYCLES clock cycles (8 by default).
- R7: After west yellow the sequence wraps to north green. With the defaults, north green comes back 64 cycles after it began.
- R8: Reset is synchronous. Raising reset between clock edges leaves the outputs unchanged until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lamp_n | output | 2 | North lamp code (10 green, 01 yellow, 00 off) |
| lamp_s | output | 2 | South lamp code |
| lamp_e | output | 2 | East lamp code |
| lamp_w | output | 2 | West lamp code |

## Verification
The hardest case to reach from the ports is a reset that arrives partway through a phase other than north green, and arrives between clock edges. That case tests both the synchronous behaviour and the clearing of the dwell count. The stimulus first runs two full laps from a walked table of expected lamp patterns. It then waits until east green is showing and raises reset at a falling edge. It checks that the lamps hold until the next rising edge. It then checks that north green starts over with its full length, ignoring the cycles the interrupted phase had already used.

// File: rtl/tl_pkg.sv
package tl_pkg;

    localparam int NUM_DIRS = 4;

    typedef logic [1:0] lamp_t;

    localparam lamp_t LAMP_OFF    = 2'b00;
    localparam lamp_t LAMP_GREEN  = 2'b10;
    localparam lamp_t LAMP_YELLOW = 2'b01;

    // Approach index: the rotation order is the numeric order.
    typedef enum logic [1:0] {
        DIR_N = 2'd0,
        DIR_S = 2'd1,
        DIR_E = 2'd2,
        DIR_W = 2'd3
    } dir_t;

    // Phase code: the upper two bits select the approach, the low bit selects yellow.
    typedef enum logic [2:0] {
        PH_N_GO   = 3'd0,
        PH_N_WARN = 3'd1,
        PH_S_GO   = 3'd2,
        PH_S_WARN = 3'd3,
        PH_E_GO   = 3'd4,
        PH_E_WARN = 3'd5,
        PH_W_GO   = 3'd6,
        PH_W_WARN = 3'd7
    } phase_t;

    typedef struct packed {
        dir_t dir;
        logic warn;
    } phase_fields_t;

    function automatic phase_fields_t split_phase(phase_t p);
        return phase_fields_t'(p);
    endfunction

    // Moves one step along the rotation; after west yellow it wraps to north green.
    function automatic phase_t next_phase(phase_t p);
        logic [2:0] raw;
        raw = p;
        raw = raw + 3'd1;
        return phase_t'(raw);
    endfunction

    function automatic lamp_t lamp_for(phase_t p, dir_t d);
        phase_fields_t f;
        f = split_phase(p);
        if (f.dir != d) return LAMP_OFF;
        return f.warn ? LAMP_YELLOW : LAMP_GREEN;
    endfunction

endpackage

// File: rtl/tl_dwell_timer.sv
module tl_dwell_timer #(
    parameter int DWELL_CYCLES = 8
) (
    input  logic clk,
    input  logic rst,
    output logic expire
);
    localparam int CW = (DWELL_CYCLES > 1) ? $clog2(DWELL_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(DWELL_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    assign expire = (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst)         cnt_q <= '0;
        else if (expire) cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/tl_phase_reg.sv
module tl_phase_reg
    import tl_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   advance,
    output phase_t phase
);
    always_ff @(posedge clk) begin
        if (rst)          phase <= PH_N_GO;
        else if (advance) phase <= next_phase(phase);
    end
endmodule

// File: rtl/tl_lamp_decode.sv
module tl_lamp_decode
    import tl_pkg::*;
(
    input  phase_t                phase,
    output lamp_t [NUM_DIRS-1:0]  lamps
);
    for (genvar g = 0; g < NUM_DIRS; g++) begin : g_dir
        assign lamps[g] = lamp_for(phase, dir_t'(2'(g)));
    end
endmodule

// File: rtl/tl_junction_rotator.sv
module tl_junction_rotator
    import tl_pkg::*;
#(
    parameter int DWELL_CYCLES = 8
) (
    input  logic       clk,
    input  logic       rst,
    output logic [1:0] lamp_n,
    output logic [1:0] lamp_s,
    output logic [1:0] lamp_e,
    output logic [1:0] lamp_w
);
    logic                  step;
    phase_t                phase;
    lamp_t [NUM_DIRS-1:0]  bank;

    tl_dwell_timer #(.DWELL_CYCLES(DWELL_CYCLES)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .expire (step)
    );

    tl_phase_reg u_phase (
        .clk     (clk),
        .rst     (rst),
        .advance (step),
        .phase   (phase)
    );

    tl_lamp_decode u_decode (
        .phase (phase),
        .lamps (bank)
    );

    assign lamp_n = bank[int'(DIR_N)];
    assign lamp_s = bank[int'(DIR_S)];
    assign lamp_e = bank[int'(DIR_E)];
    assign lamp_w = bank[int'(DIR_W)];
endmodule

// File: rtl/tl_junction_rotator_chk.sv
module tl_junction_rotator_chk #(
    parameter int DWELL_CYCLES = 8
) (
    input logic       clk,
    input logic       rst,
    input logic [1:0] lamp_n,
    input logic [1:0] lamp_s,
    input logic [1:0] lamp_e,
    input logic [1:0] lamp_w
);
    localparam int HW = $clog2(DWELL_CYCLES + 1) + 1;

    logic [7:0]    now_l;
    logic [7:0]    prev_l;
    logic [HW-1:0] held;

    assign now_l = {lamp_n, lamp_s, lamp_e, lamp_w};

    // Length of the current run of identical output patterns.
    always_ff @(posedge clk) begin
        if (rst) begin
            prev_l <= now_l;
            held   <= '0;
        end else begin
            prev_l <= now_l;
            held   <= (now_l != prev_l) ? HW'(1) : held + 1'b1;
        end
    end

    p_phase_order_r1: assert property (@(posedge clk) disable iff (rst)
        (now_l != prev_l) |-> (now_l == {prev_l[0], prev_l[7:1]}));

    p_no_code11_r3: assert property (@(posedge clk) disable iff (rst)
        (lamp_n != 2'b11) && (lamp_s != 2'b11) && (lamp_e != 2'b11) && (lamp_w != 2'b11));

    p_single_active_r4: assert property (@(posedge clk) disable iff (rst)
        $countones({|lamp_n, |lamp_s, |lamp_e, |lamp_w}) == 1);

    p_reset_north_r5: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (now_l == 8'b1000_0000));

    p_dwell_len_r6: assert property (@(posedge clk) disable iff (rst)
        (now_l != prev_l) |-> (held == HW'(DWELL_CYCLES)));

    p_dwell_cap_r6: assert property (@(posedge clk) disable iff (rst)
        (now_l == prev_l) |-> (held < HW'(DWELL_CYCLES)));
endmodule

bind tl_junction_rotator tl_junction_rotator_chk #(.DWELL_CYCLES(DWELL_CYCLES)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .lamp_n (lamp_n),
    .lamp_s (lamp_s),
    .lamp_e (lamp_e),
    .lamp_w (lamp_w)
);

// File: tb/tl_junction_rotator_bench.sv
module tl_junction_rotator_bench;
    localparam int DW = 8;

    // Expected {north, south, east, west} for each phase in rotation order.
    localparam logic [7:0] EXP_TBL [8] = '{
        8'b10_00_00_00, 8'b01_00_00_00,
        8'b00_10_00_00, 8'b00_01_00_00,
        8'b00_00_10_00, 8'b00_00_01_00,
        8'b00_00_00_10, 8'b00_00_00_01
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] lamp_n, lamp_s, lamp_e, lamp_w;
    logic [7:0] lamps;
    int         n_chk = 0;
    int         n_bad = 0;

    always #10 clk = ~clk;

    tl_junction_rotator #(.DWELL_CYCLES(DW)) u_tl_junction_rotator (
        .clk    (clk),
        .rst    (rst),
        .lamp_n (lamp_n),
        .lamp_s (lamp_s),
        .lamp_e (lamp_e),
        .lamp_w (lamp_w)
    );

    assign lamps = {lamp_n, lamp_s, lamp_e, lamp_w};

    task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic step_cycle();
        @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    function automatic int active_count(logic [7:0] v);
        int c = 0;
        for (int i = 0; i < 4; i++) if (v[2*i +: 2] != 2'b00) c++;
        return c;
    endfunction

    function automatic bit has_code11(logic [7:0] v);
        for (int i = 0; i < 4; i++) if (v[2*i +: 2] == 2'b11) return 1'b1;
        return 1'b0;
    endfunction

    initial begin
        #4_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog R7 actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        // Reset state: held for three edges (R5)
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        chk(lamps == EXP_TBL[0], "R5 reset state", lamps, EXP_TBL[0]);

        // Release reset and walk two full laps against the table
        rst = 1'b0;
        for (int k = 0; k < 16 * DW; k++) begin
            logic [7:0] exp;
            exp = EXP_TBL[(k / DW) % 8];
            if (k == 8 * DW)
                chk(lamps == exp, "R7 wrap to north green", lamps, exp);
            else
                chk(lamps == exp, "R1 R6 phase pattern", lamps, exp);
            chk(!has_code11(lamps), "R3 no code 11", lamps, exp);
            chk(active_count(lamps) == 1, "R4 one approach lit", lamps, exp);
            step_cycle();
        end

        // Run on until east green is showing (cycle index 164 since release)
        repeat (4 * DW + 4) step_cycle();
        chk(lamps == EXP_TBL[4], "R1 east green before reset", lamps, EXP_TBL[4]);

        // Mid-phase reset raised between edges (R8)
        rst = 1'b1;
        #1;
        chk(lamps == EXP_TBL[4], "R8 lamps hold until edge", lamps, EXP_TBL[4]);
        step_cycle();
        chk(lamps == EXP_TBL[0], "R5 mid-run reset to north", lamps, EXP_TBL[0]);
        step_cycle();
        rst = 1'b0;

        // North green runs its full length after the interrupted phase
        for (int k = 0; k <= DW; k++) begin
            logic [7:0] exp;
            exp = (k < DW) ? EXP_TBL[0] : EXP_TBL[1];
            chk(lamps == exp, "R5 R6 full north dwell after reset", lamps, exp);
            step_cycle();
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule